// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sequences the low-power states of a small microcontroller. It runs on the always-on slow clock. When software pulses a sleep request, the block captures a 3-bit sleep-depth code. It then switches off the clock enables of the CPU, flash, I/O and ADC domains that the code selects. In the deepest setting it also turns off the fast oscillator. Wake sources are an internal interrupt line and a level-sensitive external interrupt line. Either one ends the sleep and sends a one-cycle wake pulse to the CPU.

In the deepest setting the fast oscillator has to restart before the CPU may run again. The block therefore turns the oscillator back on and counts a fixed number of slow-clock cycles. It also waits for the oscillator's ready flag. Only then does it re-enable the CPU clock. In that setting the external level line counts as a wake only after it has stayed high for a set number of consecutive slow-clock samples. A keep-oscillator input lets the fast oscillator stay on even in the deepest setting.

Top module: `sgc_sleep_ctrl`

## Requirements
- R1: After reset every clock enable and the oscillator enable are 1 and the wake pulse is 0.
- R2: A sleep request while running stops the CPU and flash clock enables from the next cycle. Code 000 (light sleep) leaves the I/O, ADC and oscillator enables at 1.
- R3: Code 001 (quiet sleep) also drops the I/O enable, while the ADC and oscillator enables stay 1.
- R4: Code 011 (deep sleep) drops the I/O, ADC and fast-oscillator enables.
- R5: In deep sleep the fast-oscillator enable follows the keep-oscillator input, so it stays at 1 while that input is 1.
- R6: The codes 010 and 1xx behave exactly as code 000.
- R7: The code is captured with the sleep request. Changing `mode_sel` while asleep has no effect on the enables.
- R8: In light and quiet sleep, a 1 on either interrupt line, sampled at a clock edge, returns the block to running at that edge.
- R9: `wake_pulse` is 1 for exactly the first cycle back in the running state, and all enables are 1 in that cycle.
- R10: In deep sleep, `ext_irq` wakes the block only after FILT_LEN consecutive high samples. A shorter high pulse is ignored. `int_irq` wakes the block at once.
- R11: After a deep-sleep wake, the fast-oscillator enable is 1 while the CPU enable stays 0 for at least WAKE_CYC cycles and until `osc_ready` is seen high. The block is running again on the edge after the cycle in which both conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Sleep-depth code, captured with the request |
| sleep_req | input | 1 | One-cycle sleep request |
| int_irq | input | 1 | Internal wake interrupt |
| ext_irq | input | 1 | External level wake interrupt |
| osc_ready | input | 1 | Fast oscillator has stabilised |
| keep_osc | input | 1 | Hold fast oscillator on in deep sleep |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| wake_pulse | output | 1 | One-cycle wake indication to the CPU |

## Verification
Every sleep code is entered in turn: light, quiet, deep and two reserved codes. The enable pattern of each code shows whether the decode keeps the right domains running and whether a reserved code is kept away from the deeper settings. Wake is driven in several ways. A single-cycle internal pulse and a single-cycle external pulse in light or quiet sleep show that filtering applies only to deep sleep. In deep sleep, a short external burst and then a held one separate a working filter from one that is off by a sample. Deep-sleep exits are run once with `osc_ready` held low past the delay and once with it already high. This shows whether the CPU enable waits for the counter, for the ready flag, or for both.

// File: rtl/sgc_pkg.sv
package sgc_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_DOZE   = 2'd1,
      ST_SETTLE = 2'd2
   } sgc_state_e;

   localparam logic [2:0] CODE_LIGHT = 3'b000;
   localparam logic [2:0] CODE_QUIET = 3'b001;
   localparam logic [2:0] CODE_DEEP  = 3'b011;

   typedef struct packed {
      logic cpu;
      logic flash;
      logic io;
      logic adc;
      logic osc;
   } sgc_gate_t;

   localparam sgc_gate_t GATE_ALL_ON = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};

endpackage

// File: rtl/sgc_mode_decode.sv
module sgc_mode_decode
   import sgc_pkg::*;
(
   input  logic [2:0] code,
   input  logic       keep_osc,
   output sgc_gate_t  gate,
   output logic       deep
);

   always_comb begin
      gate = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
      deep = 1'b0;
      case (code)
         CODE_QUIET: begin
            gate.io = 1'b0;
         end
         CODE_DEEP: begin
            gate.io  = 1'b0;
            gate.adc = 1'b0;
            gate.osc = keep_osc;
            deep     = 1'b1;
         end
         default: begin
            deep = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/sgc_level_filter.sv
module sgc_level_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic lvl,
   output logic hit
);

   generate
      if (LEN <= 1) begin : g_direct
         assign hit = arm & lvl;
      end else begin : g_count
         localparam int CW = $clog2(LEN);
         localparam logic [CW-1:0] TOP = CW'(LEN - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (arm && lvl) begin
               run_q <= (run_q == TOP) ? run_q : run_q + 1'b1;
            end else begin
               run_q <= '0;
            end
         end

         assign hit = arm & lvl & (run_q == TOP);
      end
   endgenerate

endmodule

// File: rtl/sgc_wake_timer.sv
module sgc_wake_timer #(
   parameter int CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   generate
      if (CYC == 0) begin : g_none
         assign done = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CYC + 1);
         localparam logic [CW-1:0] LIMIT = CW'(CYC);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
            end
         end

         assign done = (cnt_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/sgc_sleep_ctrl.sv
module sgc_sleep_ctrl
   import sgc_pkg::*;
#(
   parameter int WAKE_CYC = 16,
   parameter int FILT_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_sel,
   input  logic       sleep_req,
   input  logic       int_irq,
   input  logic       ext_irq,
   input  logic       osc_ready,
   input  logic       keep_osc,
   output logic       cpu_clk_en,
   output logic       flash_clk_en,
   output logic       io_clk_en,
   output logic       adc_clk_en,
   output logic       fast_osc_en,
   output logic       wake_pulse
);

   initial begin : p_param_chk
      assert (WAKE_CYC >= 0) else $error("WAKE_CYC must not be negative");
      assert (FILT_LEN >= 1) else $error("FILT_LEN must be at least 1");
   end

   sgc_state_e state_q, state_d;
   logic [2:0] code_q;
   logic       wake_q;
   sgc_gate_t  doze_gate;
   sgc_gate_t  out_gate;
   logic       deep;
   logic       flt_hit;
   logic       settle_done;
   logic       take;

   sgc_mode_decode u_dec (
      .code     (code_q),
      .keep_osc (keep_osc),
      .gate     (doze_gate),
      .deep     (deep)
   );

   sgc_level_filter #(.LEN(FILT_LEN)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (state_q == ST_DOZE && deep),
      .lvl   (ext_irq),
      .hit   (flt_hit)
   );

   sgc_wake_timer #(.CYC(WAKE_CYC)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == ST_SETTLE),
      .done  (settle_done)
   );

   assign take = int_irq | (deep ? flt_hit : ext_irq);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_RUN:    if (sleep_req) state_d = ST_DOZE;
         ST_DOZE:   if (take) state_d = deep ? ST_SETTLE : ST_RUN;
         ST_SETTLE: if (settle_done && osc_ready) state_d = ST_RUN;
         default:   state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         code_q  <= CODE_LIGHT;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RUN && sleep_req) code_q <= mode_sel;
         wake_q <= (state_q != ST_RUN) && (state_d == ST_RUN);
      end
   end

   always_comb begin
      case (state_q)
         ST_DOZE: out_gate = doze_gate;
         ST_SETTLE: begin
            out_gate     = doze_gate;
            out_gate.osc = 1'b1;
         end
         default: out_gate = GATE_ALL_ON;
      endcase
   end

   assign cpu_clk_en   = out_gate.cpu;
   assign flash_clk_en = out_gate.flash;
   assign io_clk_en    = out_gate.io;
   assign adc_clk_en   = out_gate.adc;
   assign fast_osc_en  = out_gate.osc;
   assign wake_pulse   = wake_q;

endmodule

// File: rtl/sgc_sleep_chk.sv
module sgc_sleep_chk
   import sgc_pkg::*;
#(
   parameter int WAKE_CYC = 16
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_req,
   input logic       osc_ready,
   input logic       cpu_clk_en,
   input logic       flash_clk_en,
   input logic       io_clk_en,
   input logic       adc_clk_en,
   input logic       fast_osc_en,
   input logic       wake_pulse,
   input sgc_state_e st
);

   int unsigned settle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) settle_cnt <= 0;
      else settle_cnt <= (st == ST_SETTLE) ? settle_cnt + 1 : 0;
   end

   // R2
   sleep_stops_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && sleep_req) |=> (!cpu_clk_en && !flash_clk_en));

   // R9
   wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |=> !wake_pulse);

   // R9
   wake_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_pulse |-> (cpu_clk_en && flash_clk_en && io_clk_en && adc_clk_en));

   // R4
   osc_off_cpu_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_osc_en |-> !cpu_clk_en);

   // R11
   settle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && $past(st) == ST_SETTLE) |-> $past(osc_ready));

   // R11
   settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cpu_clk_en) && $past(st) == ST_SETTLE) |-> ($past(settle_cnt) >= WAKE_CYC));

   // R7
   doze_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DOZE && $past(st) == ST_DOZE) |-> $stable({io_clk_en, adc_clk_en}));

endmodule

bind sgc_sleep_ctrl sgc_sleep_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sleep_req    (sleep_req),
   .osc_ready    (osc_ready),
   .cpu_clk_en   (cpu_clk_en),
   .flash_clk_en (flash_clk_en),
   .io_clk_en    (io_clk_en),
   .adc_clk_en   (adc_clk_en),
   .fast_osc_en  (fast_osc_en),
   .wake_pulse   (wake_pulse),
   .st           (state_q)
);

// File: tb/sim_sgc_sleep_ctrl.sv
`timescale 1ns/1ps
module sim_sgc_sleep_ctrl;

   localparam int W = 5;
   localparam int F = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] mode_sel = 3'b000;
   logic sleep_req = 1'b0, int_irq = 1'b0, ext_irq = 1'b0;
   logic osc_ready = 1'b1, keep_osc = 1'b0;
   logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, fast_osc_en, wake_pulse;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   sgc_sleep_ctrl #(.WAKE_CYC(W), .FILT_LEN(F)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_req(sleep_req),
      .int_irq(int_irq), .ext_irq(ext_irq), .osc_ready(osc_ready), .keep_osc(keep_osc),
      .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
      .adc_clk_en(adc_clk_en), .fast_osc_en(fast_osc_en), .wake_pulse(wake_pulse)
   );

   always #5 clk = ~clk;

   wire [5:0] outs = {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, fast_osc_en, wake_pulse};

   // Behavioural reference: 0 running, 1 asleep, 2 oscillator settling
   int m_st = 0, m_code = 0, m_high = 0, m_wait = 0;
   bit m_pulse = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_code = 0; m_high = 0; m_wait = 0; m_pulse = 1'b0;
      end else begin
         m_pulse = 1'b0;
         if (m_st == 0) begin
            m_high = 0;
            if (sleep_req) begin m_code = int'(mode_sel); m_st = 1; end
         end else if (m_st == 1) begin
            bit deep_m, woke;
            deep_m = (m_code == 3);
            m_high = ext_irq ? m_high + 1 : 0;
            woke = int_irq || (deep_m ? (m_high >= F) : ext_irq);
            if (woke) begin
               m_high = 0;
               if (deep_m) begin m_st = 2; m_wait = 0; end
               else begin m_st = 0; m_pulse = 1'b1; end
            end
         end else begin
            if (m_wait >= W && osc_ready) begin m_st = 0; m_pulse = 1'b1; end
            else m_wait = m_wait + 1;
         end
      end
   end

   function automatic logic [5:0] model_out();
      logic [4:0] g;
      if (m_st == 0) g = 5'b11111;
      else if (m_st == 2) g = 5'b00001;
      else if (m_code == 1) g = 5'b00011;
      else if (m_code == 3) g = {4'b0000, keep_osc};
      else g = 5'b00111;
      return {g, m_pulse};
   endfunction

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         tests++;
         if (outs !== model_out()) begin
            fails++;
            $display("FAIL R2 model compare at %0t: got %b exp %b", $time, outs, model_out());
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [5:0] exp);
      @(negedge clk);
      tests++;
      if (outs !== exp) begin
         fails++;
         $display("FAIL %s: got %b exp %b", tag, outs, exp);
      end
   endtask

   task automatic go_sleep(input logic [2:0] m);
      mode_sel = m; sleep_req = 1'b1;
      step(1);
      sleep_req = 1'b0;
   endtask

   task automatic int_wake();
      int_irq = 1'b1;
      step(1);
      int_irq = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         fails++;
         $display("FAIL R11 watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      chk("R1 reset state", 6'b111110);

      // R2 light sleep, then internal wake (R8, R9)
      go_sleep(3'b000);
      chk("R2 light sleep enables", 6'b001110);
      int_wake();
      chk("R8 internal wake from light sleep", 6'b111111);
      step(1);
      chk("R9 wake pulse lasts one cycle", 6'b111110);

      // R3 quiet sleep, external wake is immediate (R8)
      go_sleep(3'b001);
      chk("R3 quiet sleep enables", 6'b000110);
      ext_irq = 1'b1; step(1); ext_irq = 1'b0;
      chk("R8 external wake from quiet sleep", 6'b111111);

      // R6 reserved codes
      go_sleep(3'b010);
      chk("R6 code 010 acts as light", 6'b001110);
      int_wake();
      go_sleep(3'b101);
      chk("R6 code 101 acts as light", 6'b001110);
      int_wake();
      step(1);

      // R4 deep sleep, R5 keep input, R7 mode change ignored
      keep_osc = 1'b0;
      go_sleep(3'b011);
      chk("R4 deep sleep enables", 6'b000000);
      keep_osc = 1'b1;
      chk("R5 keep input holds oscillator", 6'b000010);
      keep_osc = 1'b0;
      mode_sel = 3'b000;
      step(2);
      chk("R7 mode change while asleep ignored", 6'b000000);

      // R10 short burst ignored, full length accepted
      ext_irq = 1'b1; step(F - 1); ext_irq = 1'b0;
      step(1);
      chk("R10 short external burst ignored", 6'b000000);
      osc_ready = 1'b0;
      ext_irq = 1'b1; step(F); ext_irq = 1'b0;
      chk("R10 held external level accepted", 6'b000010);

      // R11 ready held low past the delay
      step(W + 3);
      chk("R11 waits for oscillator ready", 6'b000010);
      osc_ready = 1'b1;
      step(1);
      chk("R11 resumes after ready", 6'b111111);

      // R11 minimum delay with ready already high
      go_sleep(3'b011);
      int_wake();
      chk("R10 internal wake from deep sleep", 6'b000010);
      step(W);
      chk("R11 still settling at delay end", 6'b000010);
      step(1);
      chk("R11 running after delay", 6'b111111);
      step(2);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule